// File: doc/BRIEF.md
# Count-Controlled Loop Branch Unit

This block resolves count-controlled loop branches for a simple instruction sequencer. It keeps a loop count register, which an external agent writes through a load port. Each loop command carries the current instruction pointer and an 8-bit signed displacement. The unit takes one from the count and then tests the new value. If the new value is non-zero, the loop branches back. If it is zero, the loop falls through. In both cases the unit reports the next instruction pointer and a taken flag.

A mode input selects the counter width. In narrow mode only the low 16 bits of the count register count, and the upper half is left as it was. In wide mode all 32 bits count. Because the decrement comes before the test, a starting count of zero wraps to all ones and the loop runs the whole counter range. Commands use a valid/ready handshake. Each accepted command returns one result on the following cycle, and the unit takes a new command one cycle after that.

Top module: `loop_branch_unit`

## Requirements
- R1: After reset, `res_valid` is 0, `count_out` is 0 and `cmd_ready` is 1 while no load is requested.
- R2: A cycle with `ld_valid` high writes all 32 bits of `ld_value` into the count register, and the new value is visible on `count_out` on the next cycle.
- R3: `cmd_ready` is low whenever `ld_valid` is high or `res_valid` is high. An accepted command (`cmd_valid` and `cmd_ready` high at a rising edge) raises `res_valid` on the next cycle, for exactly one cycle, and no result appears without an accepted command.
- R4: In narrow mode (`wide_mode` = 0), each accepted command lowers bits 15:0 of the count by one modulo 2^16 and leaves bits 31:16 unchanged.
- R5: In wide mode (`wide_mode` = 1), each accepted command lowers the full 32-bit count by one modulo 2^32.
- R6: `res_taken` is 1 exactly when the decremented count, taken at the width of the mode, is non-zero. When `res_taken` is 0, `res_next_ip` equals `cmd_ip` + 2 modulo 2^16.
- R7: When `res_taken` is 1, `res_next_ip` equals `cmd_ip` + 2 + the two's-complement value of `cmd_disp` (range -128 to +127), modulo 2^16.
- R8: A count of zero wraps on its first command to 0xFFFF in the low half (narrow mode) or to 0xFFFFFFFF (wide mode), and that command is taken.
- R9: The count register holds its value in every cycle that has neither a load nor an accepted command. A command offered while `cmd_ready` is low has no effect on the count or on the result outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode | input | 1 | 0: 16-bit counter, 1: 32-bit counter |
| ld_valid | input | 1 | Write `ld_value` into the count register |
| ld_value | input | 32 | Count value to load |
| cmd_valid | input | 1 | Loop command offered |
| cmd_ready | output | 1 | Unit can accept a loop command |
| cmd_ip | input | 16 | Instruction pointer of the loop instruction |
| cmd_disp | input | 8 | Signed branch displacement |
| res_valid | output | 1 | Result valid, one cycle per accepted command |
| res_taken | output | 1 | 1: branch back, 0: fall through |
| res_next_ip | output | 16 | Next instruction pointer |
| count_out | output | 32 | Current count register value |

## Verification
Several rules are checked on every clock cycle:
- the handshake: ready is blocked during a load or a result, and each accepted command gives exactly one result;
- the decrement in each mode, including the upper half that must stay unchanged in narrow mode;
- the taken flag against the zero test at the width of the mode;
- the fall-through address, and that the count holds when the unit is idle.

Other behaviours can only be shown by the bench's scenarios:
- the signed displacement at both of its extremes;
- the wrap of the instruction pointer;
- a zero start that wraps to all ones;
- a command that collides with a load;
- a count that runs from a loaded value down to the fall-through case.

// File: rtl/lbu_pkg.sv
package lbu_pkg;
  localparam int LBU_CNT_W    = 32;
  localparam int LBU_NARROW_W = 16;
  localparam int LBU_IP_W     = 16;
  localparam int LBU_DISP_W   = 8;
  localparam int LBU_INSN_LEN = 2;

  typedef enum logic {
    CNT_NARROW = 1'b0,
    CNT_WIDE   = 1'b1
  } cnt_mode_e;
endpackage

// File: rtl/lbu_count_reg.sv
module lbu_count_reg
  import lbu_pkg::*;
#(
  parameter int CNT_W    = LBU_CNT_W,
  parameter int NARROW_W = LBU_NARROW_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wide,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec_en,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] dec_next,
  output logic             dec_zero
);
  localparam int UPPER_W = CNT_W - NARROW_W;

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] cur,
                                                 input cnt_mode_e mode);
    logic [NARROW_W-1:0] low;
    low = cur[NARROW_W-1:0] - NARROW_W'(1);
    if (mode == CNT_WIDE) return cur - CNT_W'(1);
    else                  return {cur[CNT_W-1:NARROW_W], low};
  endfunction

  function automatic logic is_spent(input logic [CNT_W-1:0] val,
                                    input cnt_mode_e mode);
    if (mode == CNT_WIDE) return (val == '0);
    else                  return (val[NARROW_W-1:0] == '0);
  endfunction

  cnt_mode_e mode;
  assign mode     = cnt_mode_e'(wide);
  assign dec_next = step_down(count, mode);
  assign dec_zero = is_spent(dec_next, mode);

  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (load_en) count <= load_val;
    else if (dec_en)  count <= dec_next;
  end

  if (UPPER_W <= 0) begin : g_bad_width
    initial $error("lbu_count_reg: CNT_W must exceed NARROW_W");
  end
endmodule

// File: rtl/lbu_target_calc.sv
module lbu_target_calc
  import lbu_pkg::*;
#(
  parameter int IP_W     = LBU_IP_W,
  parameter int DISP_W   = LBU_DISP_W,
  parameter int INSN_LEN = LBU_INSN_LEN
) (
  input  logic [IP_W-1:0]   ip,
  input  logic [DISP_W-1:0] disp,
  output logic [IP_W-1:0]   fall_ip,
  output logic [IP_W-1:0]   jump_ip
);
  localparam int EXT_W = IP_W - DISP_W;

  function automatic logic [IP_W-1:0] widen_signed(input logic [DISP_W-1:0] d);
    return {{EXT_W{d[DISP_W-1]}}, d};
  endfunction

  function automatic logic [IP_W-1:0] after_insn(input logic [IP_W-1:0] p);
    return p + IP_W'(INSN_LEN);
  endfunction

  assign fall_ip = after_insn(ip);
  assign jump_ip = fall_ip + widen_signed(disp);
endmodule

// File: rtl/loop_branch_unit.sv
module loop_branch_unit
  import lbu_pkg::*;
#(
  parameter int CNT_W    = LBU_CNT_W,
  parameter int NARROW_W = LBU_NARROW_W,
  parameter int IP_W     = LBU_IP_W,
  parameter int DISP_W   = LBU_DISP_W,
  parameter int INSN_LEN = LBU_INSN_LEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_mode,
  input  logic              ld_valid,
  input  logic [CNT_W-1:0]  ld_value,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [IP_W-1:0]   cmd_ip,
  input  logic [DISP_W-1:0] cmd_disp,
  output logic              res_valid,
  output logic              res_taken,
  output logic [IP_W-1:0]   res_next_ip,
  output logic [CNT_W-1:0]  count_out
);
  logic             cmd_accept;
  logic [CNT_W-1:0] dec_next;
  logic             dec_zero;
  logic             loop_continue;
  logic [IP_W-1:0]  fall_ip;
  logic [IP_W-1:0]  jump_ip;

  assign cmd_ready     = !res_valid && !ld_valid;
  assign cmd_accept    = cmd_valid && cmd_ready;
  assign loop_continue = !dec_zero;

  lbu_count_reg #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .wide     (wide_mode),
    .load_en  (ld_valid),
    .load_val (ld_value),
    .dec_en   (cmd_accept),
    .count    (count_out),
    .dec_next (dec_next),
    .dec_zero (dec_zero)
  );

  lbu_target_calc #(.IP_W(IP_W), .DISP_W(DISP_W), .INSN_LEN(INSN_LEN)) u_target (
    .ip      (cmd_ip),
    .disp    (cmd_disp),
    .fall_ip (fall_ip),
    .jump_ip (jump_ip)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_taken   <= 1'b0;
      res_next_ip <= '0;
    end else begin
      res_valid <= cmd_accept;
      if (cmd_accept) begin
        res_taken   <= loop_continue;
        res_next_ip <= loop_continue ? jump_ip : fall_ip;
      end
    end
  end
endmodule

// File: rtl/lbu_checker.sv
module lbu_checker #(
  parameter int CNT_W    = 32,
  parameter int NARROW_W = 16,
  parameter int IP_W     = 16,
  parameter int INSN_LEN = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wide_mode,
  input logic             ld_valid,
  input logic [CNT_W-1:0] ld_value,
  input logic             cmd_ready,
  input logic             cmd_accept,
  input logic [IP_W-1:0]  cmd_ip,
  input logic [CNT_W-1:0] count_out,
  input logic             res_valid,
  input logic             res_taken,
  input logic [IP_W-1:0]  res_next_ip
);
  p_load_writes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> count_out == $past(ld_value));

  p_ready_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid || res_valid) |-> !cmd_ready);

  p_result_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> res_valid);

  p_result_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  p_no_stray_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_accept |=> !res_valid);

  p_narrow_low_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_accept && !wide_mode) |=>
      count_out[NARROW_W-1:0] == $past(count_out[NARROW_W-1:0]) - NARROW_W'(1));

  p_narrow_upper_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_accept && !wide_mode) |=>
      count_out[CNT_W-1:NARROW_W] == $past(count_out[CNT_W-1:NARROW_W]));

  p_wide_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_accept && wide_mode) |=> count_out == $past(count_out) - CNT_W'(1));

  p_taken_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_taken == ($past(wide_mode) ? (count_out != '0)
                                                 : (count_out[NARROW_W-1:0] != '0)));

  p_fall_through_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_taken) |-> res_next_ip == $past(cmd_ip) + IP_W'(INSN_LEN));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_valid && !cmd_accept) |=> $stable(count_out));
endmodule

bind loop_branch_unit lbu_checker #(
  .CNT_W(CNT_W), .NARROW_W(NARROW_W), .IP_W(IP_W), .INSN_LEN(INSN_LEN)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wide_mode   (wide_mode),
  .ld_valid    (ld_valid),
  .ld_value    (ld_value),
  .cmd_ready   (cmd_ready),
  .cmd_accept  (cmd_accept),
  .cmd_ip      (cmd_ip),
  .count_out   (count_out),
  .res_valid   (res_valid),
  .res_taken   (res_taken),
  .res_next_ip (res_next_ip)
);

// File: tb/loop_branch_unit_tb.sv
module loop_branch_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide_mode = 1'b0;
  logic        ld_valid = 1'b0;
  logic [31:0] ld_value = '0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [15:0] cmd_ip = '0;
  logic [7:0]  cmd_disp = '0;
  logic        res_valid;
  logic        res_taken;
  logic [15:0] res_next_ip;
  logic [31:0] count_out;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  bit [31:0] m_cnt = '0;
  bit [16:0] exp_q[$];
  string     tag_q[$];

  always #5 clk = ~clk;

  loop_branch_unit u_dut (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
    .ld_valid(ld_valid), .ld_value(ld_value),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_ip(cmd_ip), .cmd_disp(cmd_disp),
    .res_valid(res_valid), .res_taken(res_taken),
    .res_next_ip(res_next_ip), .count_out(count_out)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic load_count(input bit [31:0] v);
    @(negedge clk);
    ld_valid = 1'b1;
    ld_value = v;
    @(negedge clk);
    ld_valid = 1'b0;
    m_cnt = v;
    check("R2", "count after load", count_out, v);
  endtask

  task automatic do_loop(input bit [7:0] disp, input bit [15:0] ip, input string req);
    bit taken;
    bit [15:0] nip;
    int target;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    if (wide_mode) begin
      m_cnt = m_cnt - 32'd1;
      taken = (m_cnt != 0);
    end else begin
      m_cnt[15:0] = m_cnt[15:0] - 16'd1;
      taken = (m_cnt[15:0] != 0);
    end
    target = int'(ip) + 2 + int'($signed(disp));
    nip = taken ? target[15:0] : ip + 16'd2;
    exp_q.push_back({taken, nip});
    tag_q.push_back(req);
    cmd_valid = 1'b1;
    cmd_ip    = ip;
    cmd_disp  = disp;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R3", "ready low in result cycle", {31'd0, cmd_ready}, 32'd0);
    check(req, "count after command", count_out, m_cnt);
  endtask

  // monitor: pops the scoreboard as results appear
  initial begin
    bit prev_rv = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (prev_rv && res_valid)
          check("R3", "result longer than one cycle", 32'd1, 32'd0);
        if (res_valid) begin
          if (exp_q.size() == 0) begin
            check("R3", "result without command", 32'd1, 32'd0);
          end else begin
            bit [16:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, "taken", {31'd0, res_taken}, {31'd0, e[16]});
            check(t, "next ip", {16'd0, res_next_ip}, {16'd0, e[15:0]});
          end
        end
        prev_rv = res_valid;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      check("watchdog", "run timed out", 32'd1, 32'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "res_valid after reset", {31'd0, res_valid}, 32'd0);
    check("R1", "count after reset", count_out, 32'd0);
    check("R1", "ready after reset", {31'd0, cmd_ready}, 32'd1);

    // narrow countdown from 3 with a backward displacement (R6, R7, R4)
    wide_mode = 1'b0;
    load_count(32'd3);
    do_loop(8'hFC, 16'h0100, "R7");
    do_loop(8'hFC, 16'h0100, "R7");
    do_loop(8'hFC, 16'h0100, "R6");

    // narrow: upper half kept, low half reaches zero then wraps (R4, R8)
    load_count(32'hABCD_0001);
    do_loop(8'h10, 16'h2000, "R4");
    do_loop(8'h10, 16'h2000, "R8");
    check("R4", "upper half unchanged", {16'd0, count_out[31:16]}, 32'h0000_ABCD);

    // displacement extremes and ip wrap (R7)
    load_count(32'd50);
    do_loop(8'h7F, 16'hFFF0, "R7");
    do_loop(8'h80, 16'h0010, "R7");
    do_loop(8'h80, 16'h0300, "R7");

    // wide mode decrements across the 16-bit boundary (R5)
    wide_mode = 1'b1;
    load_count(32'h0001_0000);
    do_loop(8'hF0, 16'h4000, "R5");
    load_count(32'h0001_0001);
    do_loop(8'hF0, 16'h4000, "R5");
    load_count(32'd1);
    do_loop(8'hF0, 16'h4000, "R6");
    load_count(32'd0);
    do_loop(8'hF8, 16'h5000, "R8");

    // command colliding with a load is held off and has no effect (R3, R9)
    @(negedge clk);
    ld_valid  = 1'b1;
    ld_value  = 32'h0000_0033;
    cmd_valid = 1'b1;
    cmd_ip    = 16'h7777;
    cmd_disp  = 8'h01;
    #1;
    check("R3", "ready low during load", {31'd0, cmd_ready}, 32'd0);
    @(negedge clk);
    ld_valid  = 1'b0;
    cmd_valid = 1'b0;
    m_cnt = 32'h33;
    check("R9", "count after blocked command", count_out, 32'h33);
    check("R9", "no result from blocked command", {31'd0, res_valid}, 32'd0);

    // idle cycles keep the count (R9)
    repeat (4) @(negedge clk);
    check("R9", "count held while idle", count_out, 32'h33);

    // a long run to fall-through in narrow mode (R6)
    wide_mode = 1'b0;
    load_count(32'd5);
    for (int i = 0; i < 5; i++) do_loop(8'hFE, 16'h0A00, "R6");

    repeat (3) @(negedge clk);
    check("R3", "scoreboard drained", exp_q.size(), 32'd0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule